// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (128 x 8)

This block behaves like a small byte-wide serial EEPROM on a two-wire bus. It samples SCL and SDA with a fast system clock, recognises start and stop conditions, and decodes a device address byte. It answers only when the top four address bits carry the fixed device code and the next three equal its strap pins. It pulls SDA low through an output-enable to acknowledge and to send read data. Storage is a register array of 128 bytes. It is erased to all ones at reset.

A write selects a word address and then accepts one or more data bytes into an 8-byte page buffer. Within a page, only the low three address bits advance. The buffer is written to the array only after a valid stop, once a write cycle of a fixed number of system clocks has elapsed. During that cycle the device acknowledges nothing, so a master can poll it. A write-protect pin blocks the commit. Reads begin either at the current address or, after a dummy write that sets the word address, at a chosen one. Reads continue across the whole address range for as long as the master acknowledges.

Top module: `ee_serial_mem`

## Requirements
- R1: After reset the device leaves SDA released (sda_oe low) and drives nothing until it is addressed.
- R2: The address byte following a start is sent MSB first. It is acknowledged (SDA held low during the ninth SCL pulse) only if its bits 7:4 equal the device code 1010.
- R3: Bits 3:1 of the address byte must equal strap_i[2:0] in that order for an acknowledge. Bit 0 selects the operation: 1 reads and 0 writes.
- R4: When the address byte does not match, the device gives no acknowledge and ignores every further SCL pulse until the next start.
- R5: A byte write (address, word address, one data byte, each acknowledged, then a stop) stores the byte at the word address once the write cycle ends.
- R6: In a page write every data byte is acknowledged. After each byte only word-address bits 2:0 increment, so byte nine and later wrap to the start of the same 8-byte page and overwrite earlier bytes.
- R7: A start that arrives after data bytes but before a stop abandons the write. Nothing is stored and no write cycle begins.
- R8: For WR_CYCLES clocks after a stop that ends a write with data, no byte is acknowledged. After that, a start plus a matching address is acknowledged again.
- R9: When wp_i is high at the stop, all bytes are still acknowledged, but nothing is stored and no write cycle begins.
- R10: A read returns the byte at the current address and then advances the address by one across the full 7-bit range, wrapping from 127 to 0. An acknowledge from the master asks for another byte. No acknowledge ends the read.
- R11: A read that carries no word address starts at the address after the last byte written or read.
- R12: The device changes SDA only while SCL is low, so every bit it drives stays steady throughout the SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level, as seen on the wired line |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| strap_i | input | 3 | Hard-wired address strap levels |
| wp_i | input | 1 | Write protect; high blocks commits to the array |

## Verification
The bench builds the block with a write cycle of 400 system clocks and keeps the two-stage synchroniser and the array reset to all ones. The strap pins are tied to 101. The short write cycle lets a poll land both inside the busy window and after it within a few thousand clocks. The erased reset value gives reads of untouched words a known result, which shows that an abandoned or protected write stored nothing. Page-wrap overwrites, the read wrap from 127 to 0 and address mismatches on both the code and the strap bits are all driven. A behavioural byte-array model predicts every bit sampled.

// File: rtl/ee_pkg.sv
package ee_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_RACK,
      ST_RHOLD
   } ee_state_e;

   typedef enum logic [1:0] {
      PH_DEV,
      PH_WADDR,
      PH_WDATA,
      PH_RDATA
   } ee_phase_e;

endpackage

// File: rtl/ee_line_sense.sv
module ee_line_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);

   localparam int TOP = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ee_line_sense: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [TOP:0] scl_sh;
   logic [TOP:0] sda_sh;
   logic         scl_d;
   logic         sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[TOP-1:0], scl_i};
         sda_sh <= {sda_sh[TOP-1:0], sda_i};
         scl_d  <= scl_sh[TOP];
         sda_d  <= sda_sh[TOP];
      end
   end

   assign scl_lvl   = scl_sh[TOP];
   assign sda_lvl   = sda_sh[TOP];
   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   assign bus_start = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign bus_stop  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
   parameter int AW = 7,
   parameter int DW = 8,
   parameter int PW = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear,
   input  logic                        row_load,
   input  logic [AW-PW-1:0]            row_in,
   input  logic                        wr_en,
   input  logic [PW-1:0]               wr_slot,
   input  logic [DW-1:0]               wr_data,
   output logic [AW-PW-1:0]            row_q,
   output logic [(1<<PW)-1:0]          valid_q,
   output logic [(1<<PW)-1:0][DW-1:0]  slot_q
);

   localparam int PG = 1 << PW;

   generate
      if (PW < 1 || PW >= AW) begin : g_bad_page
         $error("ee_page_buf: PW must lie between 1 and AW-1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        row_q <= '0;
      else if (row_load) row_q <= row_in;
   end

   generate
      for (genvar g = 0; g < PG; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_q[g] <= 1'b0;
               slot_q[g]  <= '0;
            end else if (clear) begin
               valid_q[g] <= 1'b0;
            end else if (wr_en && wr_slot == PW'(g)) begin
               valid_q[g] <= 1'b1;
               slot_q[g]  <= wr_data;
            end
         end
      end
   endgenerate

   // R6
   slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clear) |=> (valid_q != '0));

endmodule

// File: rtl/ee_store.sv
module ee_store #(
   parameter int          AW          = 7,
   parameter int          DW          = 8,
   parameter int          PW          = 3,
   parameter logic [7:0]  ERASED      = 8'hFF,
   parameter bit          RESET_ARRAY = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        commit,
   input  logic [AW-PW-1:0]            row_i,
   input  logic [(1<<PW)-1:0]          valid_i,
   input  logic [(1<<PW)-1:0][DW-1:0]  slot_i,
   input  logic [AW-1:0]               rd_addr,
   output logic [DW-1:0]               rd_data
);

   localparam int DEPTH = 1 << AW;
   localparam int PG    = 1 << PW;
   localparam int RW    = AW - PW;

   logic [DW-1:0] words [DEPTH];

   generate
      for (genvar w = 0; w < DEPTH; w++) begin : g_word
         localparam int SL  = w % PG;
         localparam int ROW = w / PG;
         logic          hit;
         logic [DW-1:0] word_q;

         assign hit = commit && (row_i == RW'(ROW)) && valid_i[SL];

         if (RESET_ARRAY) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   word_q <= DW'(ERASED);
               else if (hit) word_q <= slot_i[SL];
            end
         end else begin : g_nrst
            always_ff @(posedge clk) begin
               if (hit) word_q <= slot_i[SL];
            end
         end

         assign words[w] = word_q;
      end
   endgenerate

   assign rd_data = words[rd_addr];

   // R5
   commit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (valid_i != '0));

endmodule

// File: rtl/ee_serial_mem.sv
module ee_serial_mem
   import ee_pkg::*;
#(
   parameter int          AW          = 7,
   parameter int          DW          = 8,
   parameter int          PW          = 3,
   parameter logic [3:0]  DEV_CODE    = 4'b1010,
   parameter int          WR_CYCLES   = 5000,
   parameter logic [7:0]  ERASED      = 8'hFF,
   parameter bit          RESET_ARRAY = 1'b1,
   parameter int          SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [2:0] strap_i,
   input  logic       wp_i
);

   localparam int PG  = 1 << PW;
   localparam int RW  = AW - PW;
   localparam int CW  = $clog2(WR_CYCLES + 1);
   localparam int BCW = $clog2(DW + 1);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("ee_serial_mem: bus bytes are 8 bits, DW must be 8");
      end
      if (AW < 2 || AW > 8) begin : g_bad_aw
         $error("ee_serial_mem: AW must lie between 2 and 8");
      end
      if (WR_CYCLES < 1) begin : g_bad_wr
         $error("ee_serial_mem: WR_CYCLES must be at least 1");
      end
   endgenerate

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;

   ee_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .bus_start (bus_start),
      .bus_stop  (bus_stop)
   );

   ee_state_e          st;
   ee_phase_e          phase;
   logic [BCW-1:0]     bit_cnt;
   logic [DW-1:0]      shreg;
   logic [AW-1:0]      addr;
   logic               tx_after;
   logic               busy;
   logic [CW-1:0]      wcnt;

   logic                       pb_clear, commit;
   logic [RW-1:0]              pb_row;
   logic [PG-1:0]              pb_valid;
   logic [PG-1:0][DW-1:0]      pb_slots;
   logic [DW-1:0]              rd_data;

   logic bus_quiet, byte_done, dev_match;
   logic take_waddr, take_data, load_tx;

   assign bus_quiet  = !bus_start && !bus_stop;
   assign byte_done  = bus_quiet && (st == ST_RX) && scl_fall && (bit_cnt == BCW'(DW));
   assign dev_match  = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == strap_i) && !busy;
   assign take_waddr = byte_done && (phase == PH_WADDR);
   assign take_data  = byte_done && (phase == PH_WDATA);
   assign load_tx    = bus_quiet && scl_fall &&
                       (((st == ST_ACK) && tx_after) || (st == ST_RHOLD));

   // write-cycle timer
   assign commit   = busy && (wcnt == CW'(1));
   assign pb_clear = (bus_start && !busy) || (bus_stop && !busy && wp_i) || commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         wcnt <= '0;
      end else if (bus_stop && !busy && (pb_valid != '0) && !wp_i) begin
         busy <= 1'b1;
         wcnt <= CW'(WR_CYCLES);
      end else if (busy) begin
         if (commit) busy <= 1'b0;
         wcnt <= wcnt - 1'b1;
      end
   end

   // bus protocol engine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         phase    <= PH_DEV;
         bit_cnt  <= '0;
         shreg    <= '0;
         addr     <= '0;
         sda_oe   <= 1'b0;
         tx_after <= 1'b0;
      end else if (bus_start) begin
         st      <= ST_RX;
         phase   <= PH_DEV;
         bit_cnt <= '0;
         sda_oe  <= 1'b0;
      end else if (bus_stop) begin
         st     <= ST_IDLE;
         phase  <= PH_DEV;
         sda_oe <= 1'b0;
      end else if (load_tx) begin
         shreg   <= rd_data;
         addr    <= addr + 1'b1;
         sda_oe  <= ~rd_data[DW-1];
         bit_cnt <= BCW'(1);
         st      <= ST_TX;
      end else begin
         case (st)
            ST_RX: begin
               if (scl_rise && bit_cnt != BCW'(DW)) begin
                  shreg   <= {shreg[DW-2:0], sda_lvl};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (byte_done) begin
                  case (phase)
                     PH_DEV: begin
                        if (dev_match) begin
                           sda_oe   <= 1'b1;
                           st       <= ST_ACK;
                           tx_after <= shreg[0];
                           phase    <= shreg[0] ? PH_RDATA : PH_WADDR;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end
                     PH_WADDR: begin
                        sda_oe   <= 1'b1;
                        st       <= ST_ACK;
                        tx_after <= 1'b0;
                        addr     <= shreg[AW-1:0];
                        phase    <= PH_WDATA;
                     end
                     PH_WDATA: begin
                        sda_oe   <= 1'b1;
                        st       <= ST_ACK;
                        tx_after <= 1'b0;
                        addr     <= {addr[AW-1:PW], addr[PW-1:0] + 1'b1};
                     end
                     default: st <= ST_IDLE;
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  sda_oe  <= 1'b0;
                  bit_cnt <= '0;
                  st      <= ST_RX;
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bit_cnt == BCW'(DW)) begin
                     sda_oe <= 1'b0;
                     st     <= ST_RACK;
                  end else begin
                     sda_oe  <= ~shreg[DW-2];
                     shreg   <= shreg << 1;
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) st <= sda_lvl ? ST_IDLE : ST_RHOLD;
            end
            default: ;
         endcase
      end
   end

   ee_page_buf #(.AW(AW), .DW(DW), .PW(PW)) u_page (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (pb_clear),
      .row_load (take_waddr),
      .row_in   (shreg[AW-1:PW]),
      .wr_en    (take_data),
      .wr_slot  (addr[PW-1:0]),
      .wr_data  (shreg),
      .row_q    (pb_row),
      .valid_q  (pb_valid),
      .slot_q   (pb_slots)
   );

   ee_store #(
      .AW(AW), .DW(DW), .PW(PW), .ERASED(ERASED), .RESET_ARRAY(RESET_ARRAY)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (commit),
      .row_i   (pb_row),
      .valid_i (pb_valid),
      .slot_i  (pb_slots),
      .rd_addr (addr),
      .rd_data (rd_data)
   );

   // R12
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_lvl);

   // R8
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);

   // R6
   page_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(take_data) |-> (addr[AW-1:PW] == $past(addr[AW-1:PW])));

   // R10
   read_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load_tx) |-> (addr == $past(addr) + 1'b1));

endmodule

// File: tb/ee_serial_mem_bench.sv
module ee_serial_mem_bench;

   localparam int         CLK_PERIOD = 10;
   localparam int         Q          = 4;
   localparam int         WRC        = 400;
   localparam logic [2:0] STRAP      = 3'b101;
   localparam logic [7:0] DEV_W      = {4'b1010, STRAP, 1'b0};
   localparam logic [7:0] DEV_R      = {4'b1010, STRAP, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_sda = 1'b1;
   logic wp = 1'b0;
   logic sda_oe;
   logic sda_bus;

   assign sda_bus = m_sda & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   ee_serial_mem #(.WR_CYCLES(WRC)) u_ee_serial_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl),
      .sda_i   (sda_bus),
      .sda_oe  (sda_oe),
      .strap_i (STRAP),
      .wp_i    (wp)
   );

   int          nvec  = 0;
   int          nfail = 0;
   int          ref_mem [128];
   int          ref_addr = 0;
   logic [7:0]  wdata [$];

   task automatic check(input int act, input int exp, input string req);
      nvec++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic quarter();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; quarter();
      scl   = 1'b1; quarter();
      m_sda = 1'b0; quarter();
      scl   = 1'b0; quarter();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; quarter();
      scl   = 1'b1; quarter();
      m_sda = 1'b1; quarter();
   endtask

   task automatic send_bit(input logic b);
      m_sda = b; quarter();
      scl = 1'b1; quarter(); quarter();
      scl = 1'b0; quarter();
   endtask

   // samples twice while SCL is high: the two must agree (R12)
   task automatic recv_bit(output logic b);
      logic early;
      m_sda = 1'b1; quarter();
      scl = 1'b1; quarter();
      early = sda_bus; quarter();
      b = sda_bus;
      check(b, early, "R12 steady while SCL high");
      scl = 1'b0; quarter();
   endtask

   task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string req);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(a);
      check(a, exp_ack ? 0 : 1, req);
   endtask

   task automatic read_byte(input int exp, input bit more, input string req);
      logic [7:0] v;
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      check(v, exp, req);
      send_bit(more ? 1'b0 : 1'b1);
   endtask

   task automatic write_txn(input int wa, input string req);
      int a;
      bus_start();
      send_byte(DEV_W, 1, req);
      send_byte(8'(wa), 1, req);
      a = wa;
      foreach (wdata[i]) begin
         send_byte(wdata[i], 1, req);
         if (!wp) ref_mem[a] = wdata[i];
         a = (a & 8'h78) | ((a + 1) & 7);
      end
      ref_addr = a;
      bus_stop();
   endtask

   task automatic poll(input bit exp_ack, input string req);
      bus_start();
      send_byte(DEV_W, exp_ack, req);
      bus_stop();
   endtask

   task automatic read_seq(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         read_byte(ref_mem[ref_addr], i != n - 1, req);
         ref_addr = (ref_addr + 1) & 127;
      end
   endtask

   task automatic read_random(input int wa, input int n, input string req);
      bus_start();
      send_byte(DEV_W, 1, req);
      send_byte(8'(wa), 1, req);
      bus_start();
      send_byte(DEV_R, 1, req);
      ref_addr = wa;
      read_seq(n, req);
      bus_stop();
   endtask

   task automatic settle();
      repeat (WRC + 100) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) ref_mem[i] = 'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1: released after reset
      check(sda_oe, 0, "R1 reset oe");
      check(sda_bus, 1, "R1 reset line");

      // R2: wrong device code, R4: later byte ignored
      bus_start();
      send_byte({4'b1011, STRAP, 1'b0}, 0, "R2 wrong code");
      send_byte(8'h00, 0, "R4 ignored after mismatch");
      bus_stop();

      // R3: wrong strap bits
      bus_start();
      send_byte({4'b1010, 3'b100, 1'b0}, 0, "R3 wrong strap");
      send_byte(8'h00, 0, "R4 ignored after strap mismatch");
      bus_stop();

      // R5 / R8: two-byte write, poll while busy then after
      wdata.delete();
      wdata.push_back(8'h3C);
      wdata.push_back(8'h3D);
      write_txn(8'h15, "R5 write");
      poll(0, "R8 busy no ack");
      settle();
      poll(1, "R8 ack after cycle");
      read_random(8'h15, 1, "R5 readback");

      // R11: current-address read continues at 0x16
      bus_start();
      send_byte(DEV_R, 1, "R11 current read");
      read_seq(1, "R11 current read");
      bus_stop();

      // R6: ten bytes into page at 0x2D wrap and overwrite
      wdata.delete();
      for (int i = 0; i < 10; i++) wdata.push_back(8'(8'h50 + i));
      write_txn(8'h2D, "R6 page write");
      settle();
      read_random(8'h28, 9, "R6 page wrap readback");

      // R10: read wraps from 127 to 0
      wdata.delete();
      wdata.push_back(8'hE1);
      wdata.push_back(8'hE2);
      write_txn(8'h7E, "R10 setup");
      settle();
      wdata.delete();
      wdata.push_back(8'h99);
      write_txn(8'h00, "R10 setup");
      settle();
      read_random(8'h7F, 2, "R10 wrap read");

      // R9: write protect acks, stores nothing, no write cycle
      wp = 1'b1;
      wdata.delete();
      wdata.push_back(8'h00);
      write_txn(8'h15, "R9 protected write acks");
      poll(1, "R9 no write cycle");
      wp = 1'b0;
      read_random(8'h15, 1, "R9 data unchanged");

      // R7: repeated start before stop abandons the write
      bus_start();
      send_byte(DEV_W, 1, "R7 abort");
      send_byte(8'h40, 1, "R7 abort");
      send_byte(8'h77, 1, "R7 abort");
      bus_start();
      send_byte(DEV_W, 1, "R7 no busy after abort");
      bus_stop();
      poll(1, "R7 no write cycle");
      read_random(8'h40, 1, "R7 nothing stored");

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule